// File: doc/BRIEF.md
# Prescaled Modulo Timer Timebase

This block is the shared time reference for a set of capture/compare channels. A 16-bit up-counter advances on a one-cycle tick strobe in the bus clock domain. The tick comes from one of two sources. The first is the bus clock divided by a power of two from 1 to 64. The second is a filtered external timer-clock pin. When the counter reaches a software-programmed modulo value, the next tick returns it to zero and raises an overflow flag. The overflow flag can drive an interrupt request.

Software controls the block through a byte-wide register port with single-cycle read and write strobes. The register port covers these functions:
- a control/status register with the flag, interrupt enable, stop, counter-clear and source-select fields;
- the counter, as two read-only bytes;
- the modulo value, as two bytes.

Three rules make byte access safe:
- Reading the counter high byte freezes a copy of the low byte.
- Writing the modulo high byte masks overflow flagging until the low byte is written.
- The flag clears only through a read-then-write sequence, and that sequence loses against an overflow that happens inside it.

Channels take the counter value and the tick strobe directly from the output ports.

Top module: `tmr_timebase`

## Requirements
- R1: After reset the control register reads 0x20 (stop set, all else clear), the counter is 0x0000, the modulo reads 0xFFFF and the interrupt is low. The register addresses are: 0 control, 1 counter high, 2 counter low, 3 modulo high, 4 modulo low. The control bits are: 7 overflow flag, 6 interrupt enable, 5 stop, 4 clear (write only), 2:0 source select.
- R2: With source select code k in 0..6 and stop clear, the counter advances once every 2^k bus clocks.
- R3: Source select code 7 advances the counter once per rising edge of the external clock pin, where the pin must be high for at least two bus clocks and low for at least two bus clocks. A pulse one bus clock long is ignored.
- R4: When the counter equals the modulo value, the next tick loads 0x0000 and sets the overflow flag in the same cycle.
- R5: The flag clears only when a control read that sees the flag set is followed by a control write with bit 7 at 0. A write without such a read leaves the flag set.
- R6: If an overflow occurs after the arming read and before or during the clearing write, the flag stays set.
- R7: Writing 1 to the clear bit zeroes both the counter and the prescaler in that cycle, and the bit reads back 0. If stop and clear are written together, the counter stays at 0x0000.
- R8: While stop is set, the counter does not change.
- R9: A read of the counter high byte captures the low byte. The next low-byte read returns the captured value. A low-byte read without such a capture returns the live value.
- R10: After a write to the modulo high byte, wraps do not set the overflow flag until the modulo low byte is written.
- R11: The interrupt output is high exactly while the overflow flag and the interrupt enable are both 1.
- R12: Writes to the counter bytes have no effect. Control bits 4 and 3 and unmapped addresses read 0. Read data is 0 when no read strobe is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ext_clk_i | input | 1 | External timer clock pin, asynchronous |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Single-cycle write strobe |
| rd_i | input | 1 | Single-cycle read strobe |
| rdata_o | output | 8 | Read data, same cycle as rd_i |
| count_o | output | 16 | Counter value for the channels |
| tick_o | output | 1 | High in cycles where the counter advances |
| ovf_irq_o | output | 1 | Overflow interrupt request |

## Verification
A wrong prescaler phase or a stuck divider bit shows on count_o as a changed count over a whole number of periods. The run length is 2^k times a few ticks, so the error is visible within a few hundred cycles. A bad wrap compare or a mis-armed flag clear shows on the cycle after the count reaches the modulo, or on the very next control read: the count does not drop to zero, or the flag and interrupt are not set, or they clear when they should not. Stale low-byte capture and modulo-write masking are each exposed by a single register read after a known number of wraps or cycles.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CNT_W   = 16;
  localparam int PS_W    = 3;
  localparam int DIV_W   = (1 << PS_W) - 2;

  typedef enum logic [2:0] {
    A_CTRL   = 3'd0,
    A_CNT_HI = 3'd1,
    A_CNT_LO = 3'd2,
    A_MOD_HI = 3'd3,
    A_MOD_LO = 3'd4
  } reg_addr_e;

  localparam int B_OVF  = 7;
  localparam int B_IE   = 6;
  localparam int B_STOP = 5;
  localparam int B_CLR  = 4;

  localparam logic [PS_W-1:0] PSEL_EXT = '1;
endpackage

// File: rtl/tmr_ext_filter.sv
module tmr_ext_filter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_i,
  output logic rise_o
);
  localparam int SH_W = SYNC_STAGES + 2;

  logic [SH_W-1:0] sh_q;
  logic            lvl_q;
  logic            qual_hi, qual_lo;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SH_W-2:0], ext_i};
  end

  // level must hold for two consecutive synchronised samples
  assign qual_hi = sh_q[SH_W-1] & sh_q[SH_W-2];
  assign qual_lo = ~(sh_q[SH_W-1] | sh_q[SH_W-2]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lvl_q <= 1'b0;
    else if (qual_hi) lvl_q <= 1'b1;
    else if (qual_lo) lvl_q <= 1'b0;
  end

  assign rise_o = qual_hi & ~lvl_q;
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            clr_i,
  input  logic [PS_W-1:0] psel_i,
  input  logic            ext_rise_i,
  output logic            tick_o
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W:0]   mask_w;
  logic [DIV_W-1:0] mask;
  logic             mask_unused;
  logic             int_tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (clr_i)  div_q <= '0;
    else if (run_i)  div_q <= div_q + 1'b1;
  end

  assign mask_w      = ((DIV_W+1)'(1) << psel_i) - (DIV_W+1)'(1);
  assign mask        = mask_w[DIV_W-1:0];
  assign mask_unused = mask_w[DIV_W];
  assign int_tick    = (div_q & mask) == mask;

  assign tick_o = run_i & ~clr_i & ((psel_i == PSEL_EXT) ? ext_rise_i : int_tick);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] mod_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  assign wrap_o = tick_i & ~clr_i & (cnt_q == mod_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (wrap_o)  cnt_q <= '0;
    else if (tick_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tmr_timebase.sv
module tmr_timebase
  import tmr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ext_clk_i,
  input  logic [2:0]  addr_i,
  input  logic [7:0]  wdata_i,
  input  logic        wr_i,
  input  logic        rd_i,
  output logic [7:0]  rdata_o,
  output logic [15:0] count_o,
  output logic        tick_o,
  output logic        ovf_irq_o
);
  logic            ie_q, stop_q, ovf_q, arm_q, mod_inh_q, hold_v_q;
  logic [PS_W-1:0] psel_q;
  logic [CNT_W-1:0] mod_q;
  logic [7:0]      lo_hold_q;
  logic            wr_ctrl, rd_ctrl, wr_mod_hi, wr_mod_lo, rd_cnt_hi, rd_cnt_lo;
  logic            run, soft_clr, ext_rise, wrap, ovf_set;
  logic            ctrl_unused;

  assign wr_ctrl   = wr_i && addr_i == A_CTRL;
  assign rd_ctrl   = rd_i && addr_i == A_CTRL;
  assign wr_mod_hi = wr_i && addr_i == A_MOD_HI;
  assign wr_mod_lo = wr_i && addr_i == A_MOD_LO;
  assign rd_cnt_hi = rd_i && addr_i == A_CNT_HI;
  assign rd_cnt_lo = rd_i && addr_i == A_CNT_LO;

  assign run         = ~stop_q;
  assign soft_clr    = wr_ctrl & wdata_i[B_CLR];
  assign ctrl_unused = wdata_i[3];

  tmr_ext_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ext_i  (ext_clk_i),
    .rise_o (ext_rise)
  );

  tmr_prescaler u_ps (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run),
    .clr_i      (soft_clr),
    .psel_i     (psel_q),
    .ext_rise_i (ext_rise),
    .tick_o     (tick_o)
  );

  tmr_counter u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_o),
    .clr_i  (soft_clr),
    .mod_i  (mod_q),
    .cnt_o  (count_o),
    .wrap_o (wrap)
  );

  assign ovf_set = wrap & ~mod_inh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q   <= 1'b0;
      stop_q <= 1'b1;
      psel_q <= '0;
    end else if (wr_ctrl) begin
      ie_q   <= wdata_i[B_IE];
      stop_q <= wdata_i[B_STOP];
      psel_q <= wdata_i[PS_W-1:0];
    end
  end

  // two-step clear; any overflow in between disarms it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q <= 1'b0;
      arm_q <= 1'b0;
    end else begin
      if (ovf_set)                                  ovf_q <= 1'b1;
      else if (wr_ctrl && !wdata_i[B_OVF] && arm_q) ovf_q <= 1'b0;

      if (ovf_set || wr_ctrl)   arm_q <= 1'b0;
      else if (rd_ctrl && ovf_q) arm_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mod_q     <= '1;
      mod_inh_q <= 1'b0;
    end else if (wr_mod_hi) begin
      mod_q[15:8] <= wdata_i;
      mod_inh_q   <= 1'b1;
    end else if (wr_mod_lo) begin
      mod_q[7:0]  <= wdata_i;
      mod_inh_q   <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_hold_q <= '0;
      hold_v_q  <= 1'b0;
    end else if (rd_cnt_hi) begin
      lo_hold_q <= count_o[7:0];
      hold_v_q  <= 1'b1;
    end else if (rd_cnt_lo) begin
      hold_v_q  <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (addr_i)
        A_CTRL:   rdata_o = {ovf_q, ie_q, stop_q, 2'b00, psel_q};
        A_CNT_HI: rdata_o = count_o[15:8];
        A_CNT_LO: rdata_o = hold_v_q ? lo_hold_q : count_o[7:0];
        A_MOD_HI: rdata_o = mod_q[15:8];
        A_MOD_LO: rdata_o = mod_q[7:0];
        default:  rdata_o = '0;
      endcase
    end
  end

  assign ovf_irq_o = ovf_q & ie_q;
endmodule

// File: rtl/tmr_timebase_chk.sv
module tmr_timebase_chk
  import tmr_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run,
  input logic             soft_clr,
  input logic             tick_o,
  input logic [CNT_W-1:0] count_o,
  input logic [CNT_W-1:0] mod_q,
  input logic             ovf_set,
  input logic             ovf_q,
  input logic             mod_inh_q,
  input logic             ie_q,
  input logic [PS_W-1:0]  psel_q,
  input logic             ovf_irq_o
);
  // R2
  div_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && psel_q == '0 && !soft_clr) |-> tick_o);

  // R4
  wrap_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && count_o == mod_q && !soft_clr) |=> count_o == '0);

  // R6
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_set |=> ovf_q);

  // R7
  soft_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_clr |=> count_o == '0);

  // R8
  stop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !soft_clr) |=> $stable(count_o));

  // R10
  mod_inhibit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mod_inh_q && !ovf_q) |=> !ovf_q);

  // R11
  irq_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_irq_o) |-> ie_q);
endmodule

bind tmr_timebase tmr_timebase_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .run       (run),
  .soft_clr  (soft_clr),
  .tick_o    (tick_o),
  .count_o   (count_o),
  .mod_q     (mod_q),
  .ovf_set   (ovf_set),
  .ovf_q     (ovf_q),
  .mod_inh_q (mod_inh_q),
  .ie_q      (ie_q),
  .psel_q    (psel_q),
  .ovf_irq_o (ovf_irq_o)
);

// File: tb/tmr_timebase_test.sv
module tmr_timebase_test;
  localparam time CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_clk = 1'b0;
  logic [2:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  rdata;
  logic [15:0] count;
  logic        tick, irq;

  int vectors = 0;
  int fails = 0;
  logic [15:0] snap;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_timebase uut (
    .clk_i(clk), .rst_ni(rst_n), .ext_clk_i(ext_clk),
    .addr_i(addr), .wdata_i(wdata), .wr_i(wr_en), .rd_i(rd_en),
    .rdata_o(rdata), .count_o(count), .tick_o(tick), .ovf_irq_o(irq)
  );

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rdata; snap = count;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 count", count, 0);
    check("R1 irq", irq, 0);
    rd(0, d); check("R1 ctrl", d, 8'h20);
    rd(3, d); check("R1 mod hi", d, 8'hFF);
    rd(4, d); check("R1 mod lo", d, 8'hFF);
    repeat (20) @(negedge clk);
    check("R8 stopped after reset", count, 0);
  endtask

  task automatic t_prescale();
    logic [15:0] c0;
    for (int k = 0; k < 7; k++) begin
      wr(0, 8'h30 | 8'(k));
      wr(0, 8'(k));
      c0 = count;
      do @(negedge clk); while (count == c0);
      c0 = count;
      repeat (5 << k) @(negedge clk);
      check($sformatf("R2 divide code %0d", k), count, c0 + 5);
    end
  endtask

  task automatic t_latch();
    logic [7:0] d;
    logic [15:0] s;
    wr(0, 8'h30); wr(0, 8'h00);
    repeat (300) @(negedge clk);
    rd(1, d); s = snap;
    check("R9 hi byte", d, s[15:8]);
    repeat (7) @(negedge clk);
    rd(2, d);
    check("R9 captured lo", d, s[7:0]);
    rd(2, d);
    check("R9 live lo", d, snap[7:0]);
  endtask

  task automatic t_softclr();
    logic [7:0] d;
    wr(0, 8'h10);
    check("R7 clear running", count, 0);
    rd(0, d); check("R7 clear bit reads 0", d, 8'h00);
    wr(0, 8'h30);
    repeat (20) @(negedge clk);
    check("R7 stop+clear holds 0", count, 0);
    wr(0, 8'h36); wr(0, 8'h06);
    repeat (63) @(negedge clk);
    check("R7 prescaler cleared, before tick", count, 0);
    @(negedge clk);
    check("R7 prescaler cleared, first tick", count, 1);
    wr(0, 8'h20);
    repeat (5) @(negedge clk);
    check("R8 stop freezes", count, 1);
  endtask

  task automatic t_wrap();
    logic [7:0] d;
    wr(0, 8'h30); wr(3, 8'h00); wr(4, 8'h04); wr(0, 8'h40);
    while (count != 4) @(negedge clk);
    check("R4 no flag before wrap", irq, 0);
    @(negedge clk);
    check("R4 wraps to 0", count, 0);
    check("R11 irq on flag", irq, 1);
    wr(0, 8'h00);
    check("R11 irq masked", irq, 0);
    wr(0, 8'h40);
    check("R5 write without read keeps flag", irq, 1);
  endtask

  task automatic t_race();
    logic [7:0] d;
    while (count != 1) @(negedge clk);
    rd(0, d);
    check("R6 flag seen", d[7], 1);
    while (count != 4) @(negedge clk);
    @(negedge clk);
    wr(0, 8'h40);
    rd(0, d);
    check("R6 racing overflow keeps flag", d[7], 1);
  endtask

  task automatic t_clear();
    logic [7:0] d;
    wr(0, 8'h60);
    rd(0, d); check("R5 flag before clear", d, 8'hE0);
    wr(0, 8'h60);
    rd(0, d); check("R5 flag cleared", d, 8'h60);
    check("R11 irq low after clear", irq, 0);
  endtask

  task automatic t_inhibit();
    logic [7:0] d;
    wr(3, 8'h00);
    wr(0, 8'h00);
    repeat (30) @(negedge clk);
    wr(0, 8'h20);
    rd(0, d); check("R10 no flag while mod half written", d, 8'h20);
    wr(4, 8'h04);
    wr(0, 8'h00);
    repeat (12) @(negedge clk);
    rd(0, d); check("R10 flag after mod complete", d, 8'h80);
    wr(0, 8'h20);
    rd(0, d); wr(0, 8'h20);
  endtask

  task automatic t_ext();
    wr(0, 8'h37); wr(0, 8'h07);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); ext_clk = 1'b1;
      @(negedge clk); ext_clk = 1'b0;
      repeat (3) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    check("R3 short pulses ignored", count, 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); ext_clk = 1'b1;
      repeat (3) @(negedge clk); ext_clk = 1'b0;
      repeat (3) @(negedge clk);
    end
    repeat (8) @(negedge clk);
    check("R3 qualified edges counted", count, 4);
  endtask

  task automatic t_ro();
    logic [7:0] d;
    wr(0, 8'h3F);
    rd(0, d); check("R12 unused ctrl bits", d, 8'h27);
    wr(1, 8'hAB); wr(2, 8'hCD);
    rd(1, d); check("R12 count hi not writable", d, 8'h00);
    rd(2, d); check("R12 count lo not writable", d, 8'h00);
    rd(5, d); check("R12 unmapped address", d, 8'h00);
    @(negedge clk); addr = 3'd3; #1;
    check("R12 no strobe reads 0", rdata, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_prescale();
    t_latch();
    t_softclr();
    t_wrap();
    t_race();
    t_clear();
    t_inhibit();
    t_ext();
    t_ro();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    vectors++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule